// File: doc/BRIEF.md
# Serial-Programmed Glitch-Free Output Clock Gate

This block stops and restarts a set of output clocks under serial control. A free-running serial clock samples a single data line. While the line sits high the receiver waits. A low start bit opens a frame, and a fixed number of control bits follows, one per serial clock period. When the last bit has arrived, the whole word is moved into a control register in one step. Each controllable output clock then runs or stays at logic low, according to its bit.

The block has three banks of four clocks and a feedback clock. Eleven of them can be gated. The first clock of the third bank and the feedback clock always run. Each control bit crosses into its own clock's domain through two flops on the rising edge. The gate enable is then re-registered on the falling edge, so it changes only while that clock is low. This keeps every high pulse at full width.

Top module: `clkstop_gate`

## Requirements
- R1: While idle, a high data line keeps the receiver waiting. A low level sampled on a rising edge of `ser_clk` is taken as a start bit.
- R2: Exactly 12 control bits follow the start bit, one per `ser_clk` period, each sampled on a rising edge. The start bit of the next frame may come in the very next period.
- R3: Control bit index i is the i-th bit after the start bit. Indices 0..3 map to `qa[0..3]`, 4..7 to `qb[0..3]`, and 8..10 to `qc[1..3]`. Index 11 is reserved and has no effect.
- R4: A control bit of 1 lets its output follow its input clock. A bit of 0 holds that output at logic 0.
- R5: A new control word takes effect only after all 12 bits have been received. A frame in progress leaves the outputs as they were.
- R6: After reset every output runs.
- R7: `qc[0]` and `qfb` run at all times, whatever the control word.
- R8: A gate opens or closes only while its clock is low, so every high pulse on an output lasts a full half period of its input clock.
- R9: A new control bit reaches its gate through two rising-edge flops and one falling-edge flop of that output's clock. It therefore applies within three periods of that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Free-running serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| ser_data | input | 1 | Serial control data, idle high |
| ca | input | BANK | Bank A source clocks |
| cb | input | BANK | Bank B source clocks |
| cc | input | BANK | Bank C source clocks |
| cfb | input | 1 | Feedback source clock |
| qa | output | BANK | Gated bank A clocks |
| qb | output | BANK | Gated bank B clocks |
| qc | output | BANK | Bank C clocks, element 0 ungated |
| qfb | output | 1 | Feedback clock, ungated |

## Verification
The bench sends frames and compares the set of outputs that toggle with the expected set. A walking one through every bit position would catch a design that mis-maps or reverses the bit order. A frame that differs only in the reserved bit would catch a design that lets that bit reach a gate. The bench watches an output that a frame will stop while that frame is still arriving; a design that applies bits as they shift in would stop it early. Back-to-back frames with no idle bit between them would throw a receiver that needs an idle bit out of frame. The bench also measures the width of every high pulse on every output. Gating on the rising edge would leave a truncated pulse, which this measurement reports.

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int BANK       = 4,
  parameter int FRAME_BITS = 12
) (
  input  logic            ser_clk,
  input  logic            rst_n,
  input  logic            ser_data,
  input  logic [BANK-1:0] ca,
  input  logic [BANK-1:0] cb,
  input  logic [BANK-1:0] cc,
  input  logic            cfb,
  output logic [BANK-1:0] qa,
  output logic [BANK-1:0] qb,
  output logic [BANK-1:0] qc,
  output logic            qfb
);
  localparam int NCTL  = 3 * BANK - 1;
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [NCTL-1:0]  sreg, ctrl, shifted;
  logic             take;

  assign shifted = {ser_data, sreg[NCTL-1:1]};
  assign take    = cnt < CNT_W'(NCTL);

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sreg <= '0;
      ctrl <= '1;
    end else if (!busy) begin
      cnt <= '0;
      if (!ser_data) busy <= 1'b1;
    end else begin
      if (take) sreg <= shifted;
      if (cnt == CNT_W'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
        ctrl <= take ? shifted : sreg;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic [NCTL-1:0] clk_ctl, sync2, en, q_ctl;
  assign clk_ctl = {cc[BANK-1:1], cb, ca};

  for (genvar i = 0; i < NCTL; i++) begin : g_gate
    logic s1, s2, e;
    always_ff @(posedge clk_ctl[i] or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= ctrl[i];
        s2 <= s1;
      end
    end
    always_ff @(negedge clk_ctl[i] or negedge rst_n) begin
      if (!rst_n) e <= 1'b1;
      else        e <= s2;
    end
    assign sync2[i] = s2;
    assign en[i]    = e;
  end

  assign q_ctl = clk_ctl & en;
  assign qa    = q_ctl[BANK-1:0];
  assign qb    = q_ctl[2*BANK-1:BANK];
  assign qc    = {q_ctl[NCTL-1:2*BANK], cc[0]};
  assign qfb   = cfb;
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int NCTL       = 11,
  parameter int FRAME_BITS = 12,
  parameter int CNT_W      = 4
) (
  input logic             ser_clk,
  input logic             rst_n,
  input logic             ser_data,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [NCTL-1:0]  ctrl,
  input logic [NCTL-1:0]  clk_ctl,
  input logic [NCTL-1:0]  sync2
);
  a_r1_idle_wait: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && ser_data) |=> !busy);

  a_r1_start: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && !ser_data) |=> (busy && cnt == '0));

  a_r2_count: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && cnt != CNT_W'(FRAME_BITS - 1)) |=> (busy && cnt == $past(cnt) + 1'b1));

  a_r5_ctrl_at_end: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !$stable(ctrl) |-> ($past(busy) && $past(cnt) == CNT_W'(FRAME_BITS - 1)));

  for (genvar i = 0; i < NCTL; i++) begin : g_sync
    a_r9_sync_path: assert property (@(posedge clk_ctl[i]) disable iff (!rst_n)
      sync2[i] == $past(ctrl[i], 2));
  end
endmodule

bind clkstop_gate clkstop_gate_chk #(
  .NCTL(NCTL), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
) u_chk (
  .ser_clk(ser_clk), .rst_n(rst_n), .ser_data(ser_data), .busy(busy),
  .cnt(cnt), .ctrl(ctrl), .clk_ctl(clk_ctl), .sync2(sync2)
);

// File: tb/clkstop_gate_test.sv
module clkstop_gate_test;
  logic ser_clk = 0, rst_n = 0, ser_data = 1;
  logic ka = 0, kb = 0, kc = 0, kf = 0;
  always #5 ser_clk = ~ser_clk;
  always #4 ka = ~ka;
  always #6 kb = ~kb;
  always #10 kc = ~kc;
  always #8 kf = ~kf;

  logic [3:0] qa, qb, qc;
  logic qfb;
  wire [12:0] q_all = {qfb, qc, qb, qa};

  clkstop_gate uut (.ser_clk(ser_clk), .rst_n(rst_n), .ser_data(ser_data),
    .ca({4{ka}}), .cb({4{kb}}), .cc({4{kc}}), .cfb(kf),
    .qa(qa), .qb(qb), .qc(qc), .qfb(qfb));

  int checks = 0, fails = 0, runt_errs = 0, pulses = 0;
  int rises[13];
  bit done = 0;
  logic [12:0] exp_q[$];
  string tag_q[$];

  function automatic real half(int g);
    return g < 4 ? 4.0 : g < 8 ? 6.0 : g < 12 ? 10.0 : 8.0;
  endfunction

  function automatic logic [12:0] mask_of(logic [11:0] b);
    return {1'b1, b[10:8], 1'b1, b[7:4], b[3:0]};
  endfunction

  for (genvar g = 0; g < 13; g++) begin : g_mon
    real t_r;
    bit seen = 0;
    always @(posedge q_all[g]) begin
      t_r = $realtime;
      seen = 1;
      rises[g]++;
    end
    always @(negedge q_all[g]) if (seen && rst_n) begin
      pulses++;
      if ($realtime - t_r != half(g)) runt_errs++;
    end
  end

  // scoreboard monitor
  initial forever begin
    int r0[13];
    logic [12:0] run;
    wait (exp_q.size() > 0);
    #150;
    r0 = rises;
    #200;
    for (int g = 0; g < 13; g++) run[g] = (rises[g] != r0[g]) || (q_all[g] !== 1'b0);
    checks++;
    if (run !== exp_q[0]) begin
      fails++;
      $display("FAIL %s running actual=%b expected=%b", tag_q[0], run, exp_q[0]);
    end
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  task automatic send_frame(input logic [11:0] b, input bit tail);
    @(negedge ser_clk) ser_data <= 1'b0;
    for (int i = 0; i < 12; i++) @(negedge ser_clk) ser_data <= b[i];
    if (tail) @(negedge ser_clk) ser_data <= 1'b1;
  endtask

  task automatic expect_mask(input logic [12:0] m, input string tag);
    tag_q.push_back(tag);
    exp_q.push_back(m);
    wait (exp_q.size() == 0);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int snap, s0, s11;
    #100 rst_n = 1;
    #20;
    expect_mask(13'h1fff, "R6 reset all running");
    send_frame(12'h000, 1); expect_mask(mask_of(12'h000), "R4 R7 all stopped");
    send_frame(12'hfff, 1); expect_mask(mask_of(12'hfff), "R4 all running");
    send_frame(12'h555, 1); expect_mask(mask_of(12'h555), "R3 pattern 555");
    send_frame(12'haaa, 1); expect_mask(mask_of(12'haaa), "R3 pattern aaa");
    for (int k = 0; k < 11; k++) begin
      send_frame(12'(1 << k), 1);
      expect_mask(mask_of(12'(1 << k)), "R3 walking one");
    end
    send_frame(12'h0f0, 1); expect_mask(mask_of(12'h0f0), "R3 base");
    send_frame(12'h8f0, 1); expect_mask(mask_of(12'h0f0), "R3 reserved bit ignored");
    #400;
    expect_mask(mask_of(12'h0f0), "R1 idle high holds state");
    send_frame(12'hfff, 1); expect_mask(mask_of(12'hfff), "R4 re-enable");
    // R5: outputs unchanged while a frame is arriving
    @(negedge ser_clk) ser_data <= 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge ser_clk) ser_data <= 1'b0;
      if (i == 5) snap = rises[0];
      if (i == 11) check(rises[0] - snap >= 4, "R5 A0 runs mid-frame", rises[0] - snap, 4);
    end
    @(negedge ser_clk) ser_data <= 1'b1;
    // R9: stopped within three periods of its own clock
    #65;
    s0 = rises[0];
    s11 = rises[11];
    #60;
    check(rises[0] == s0, "R9 A0 stopped in time", rises[0] - s0, 0);
    check(rises[11] == s11, "R9 C3 stopped in time", rises[11] - s11, 0);
    expect_mask(mask_of(12'h000), "R5 frame applied at end");
    send_frame(12'h00f, 0);
    send_frame(12'hff0, 1);
    expect_mask(mask_of(12'hff0), "R2 back-to-back frames");
    check(runt_errs == 0 && pulses > 0, "R8 full-width pulses", runt_errs, 0);
    finish_run();
  end
endmodule